// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block sums signed 16-bit by 16-bit products into a 42-bit accumulator. The accumulator is held as two parts: a 32-bit low word and a 10-bit high extension. A command port accepts at most one operation per clock. The operations are:

- clear the accumulator;
- load either part from a 32-bit word;
- read either part back;
- add the product of two operand words to the accumulator.

The operands arrive already fetched, together with the command strobe. Address generation and memory traffic stay with the host.

A read returns the selected part one cycle after the command, with a one-cycle result strobe. The high part comes back sign-extended to 32 bits. Each read also refreshes a set of condition flags. Zero and negative describe the entire 42-bit accumulator, not just the part that was read. Overflow and carry are always returned clear, because the sum wraps modulo 2^42 and never saturates.

Top module: `smac_unit`

## Requirements
- R1: A clear command (`cmd_op` = 1) zeroes all 42 bits. A following read of either part returns 0, with `flag_z` = 1 and `flag_n` = 0 and `flag_v` = 0.
- R2: A multiply-accumulate command (`cmd_op` = 6) adds `opa` × `opb` to the accumulator. Both operands are taken as signed two's complement, and the 32-bit product is sign-extended to 42 bits. For example, clearing and then accumulating -2 × 2 reads back low 0xFFFFFFFC and high 0xFFFFFFFF.
- R3: Loading the high part (`cmd_op` = 2) keeps only bits 9:0 of `ld_data`. Reading the high part (`cmd_op` = 4) returns those 10 bits sign-extended to 32 bits. For example, loading 0xA5A5A5A5 reads back as 0x000001A5.
- R4: Loading the low part (`cmd_op` = 3) keeps all 32 bits. Reading the low part (`cmd_op` = 5) returns the value unchanged.
- R5: A load of either part returns `flag_v` and `flag_c` to 0 and leaves `flag_z` and `flag_n` as they were.
- R6: A carry out of the low word goes into the high part, and the 42-bit sum wraps. For example, eight accumulations of 0x7FFF × 0x7FFF read back low 0xFFF80008 and high 1, with `flag_n` = 0.
- R7: On a read, `flag_z` is 1 exactly when all 42 accumulator bits are 0. A zero high part with a nonzero low part reads back with `flag_z` = 0, and so does the reverse.
- R8: On a read, `flag_n` equals accumulator bit 41.
- R9: A read always returns `flag_v` = 0 and `flag_c` = 0, including after any number of accumulations.
- R10: A read command raises `res_valid` for exactly the next cycle, with `res_data` and the flags updated in that same cycle. The result includes every command issued before the read. `res_data` holds its value between reads.
- R11: A synchronous active-high `rst` clears the accumulator, the result register and all flags.
- R12: A command with `cmd_valid` = 0, or with `cmd_op` equal to 0 or 7, changes neither the accumulator nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 none, 1 clear, 2 load high, 3 load low, 4 read high, 5 read low, 6 accumulate, 7 none) |
| ld_data | input | 32 | Load value |
| opa | input | 16 | First signed operand |
| opb | input | 16 | Second signed operand |
| res_valid | output | 1 | Read result strobe |
| res_data | output | 32 | Read result |
| flag_z | output | 1 | Whole accumulator is zero |
| flag_n | output | 1 | Accumulator sign bit |
| flag_v | output | 1 | Overflow, always 0 |
| flag_c | output | 1 | Carry, always 0 |

## Verification
A wrong accumulator bit cannot be seen directly. It shows up only on the next read, one cycle after that read's command. The read exposes it in one of three ways:
- directly in `res_data`, if the bit lies in the part being read;
- through `flag_z` and `flag_n`, if the bit lies in the other part;
- through the 22 replicated sign bits of `res_data`, if the bit is in the high extension.

For this reason the reference model is compared on every clock, and every scenario ends by reading both parts. A lost carry between the two parts appears only once the low word wraps. This is why the 0x7FFF sequence, an all-ones carry and the wrap at 2^41 are each exercised.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_CLR   = 3'd1,
    CMD_LDHI  = 3'd2,
    CMD_LDLO  = 3'd3,
    CMD_RDHI  = 3'd4,
    CMD_RDLO  = 3'd5,
    CMD_MAC   = 3'd6,
    CMD_SPARE = 3'd7
  } smac_cmd_e;
endpackage

// File: rtl/smac_mult.sv
module smac_mult #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 42
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  output logic [ACC_W-1:0] prod_ext
);
  localparam int PROD_W = 2 * OP_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;

  always_comb prod = $signed(a) * $signed(b);

  generate
    if (EXT_W > 0) begin : g_ext
      assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
    end else begin : g_noext
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/smac_acc.sv
module smac_acc
  import smac_pkg::*;
#(
  parameter int LO_W = 32,
  parameter int HI_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  smac_cmd_e            op,
  input  logic [LO_W-1:0]      ld_data,
  input  logic [HI_W+LO_W-1:0] addend,
  output logic [HI_W-1:0]      hi_q,
  output logic [LO_W-1:0]      lo_q
);
  logic [LO_W:0]   lo_sum;
  logic [HI_W-1:0] hi_sum;

  // Split adder: low word first, its carry feeds the high extension.
  always_comb begin
    lo_sum = {1'b0, lo_q} + {1'b0, addend[LO_W-1:0]};
    hi_sum = hi_q + addend[HI_W+LO_W-1:LO_W] + {{(HI_W-1){1'b0}}, lo_sum[LO_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (en) begin
      unique case (op)
        CMD_CLR: begin
          hi_q <= '0;
          lo_q <= '0;
        end
        CMD_LDHI: hi_q <= ld_data[HI_W-1:0];
        CMD_LDLO: lo_q <= ld_data;
        CMD_MAC: begin
          hi_q <= hi_sum;
          lo_q <= lo_sum[LO_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smac_rd.sv
module smac_rd
  import smac_pkg::*;
#(
  parameter int LO_W = 32,
  parameter int HI_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  smac_cmd_e       op,
  input  logic [HI_W-1:0] hi,
  input  logic [LO_W-1:0] lo,
  output logic            vld_q,
  output logic [LO_W-1:0] data_q,
  output logic            z_q,
  output logic            n_q,
  output logic            v_q,
  output logic            c_q
);
  logic [LO_W-1:0] hi_sext;
  logic            acc_zero;

  always_comb begin
    hi_sext  = {{(LO_W-HI_W){hi[HI_W-1]}}, hi};
    acc_zero = (hi == '0) && (lo == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      z_q    <= 1'b0;
      n_q    <= 1'b0;
      v_q    <= 1'b0;
      c_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (en) begin
        unique case (op)
          CMD_RDHI, CMD_RDLO: begin
            vld_q  <= 1'b1;
            data_q <= (op == CMD_RDHI) ? hi_sext : lo;
            z_q    <= acc_zero;
            n_q    <= hi[HI_W-1];
            v_q    <= 1'b0;
            c_q    <= 1'b0;
          end
          CMD_LDHI, CMD_LDLO: begin
            v_q <= 1'b0;
            c_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int OP_W = 16,
  parameter int LO_W = 32,
  parameter int HI_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [LO_W-1:0] ld_data,
  input  logic [OP_W-1:0] opa,
  input  logic [OP_W-1:0] opb,
  output logic            res_valid,
  output logic [LO_W-1:0] res_data,
  output logic            flag_z,
  output logic            flag_n,
  output logic            flag_v,
  output logic            flag_c
);
  localparam int ACC_W = HI_W + LO_W;

  smac_cmd_e       op;
  logic [ACC_W-1:0] prod_ext;
  logic [HI_W-1:0]  acc_hi;
  logic [LO_W-1:0]  acc_lo;

  assign op = smac_cmd_e'(cmd_op);

  smac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .a(opa), .b(opb), .prod_ext(prod_ext)
  );

  smac_acc #(.LO_W(LO_W), .HI_W(HI_W)) u_acc (
    .clk(clk), .rst(rst), .en(cmd_valid), .op(op),
    .ld_data(ld_data), .addend(prod_ext), .hi_q(acc_hi), .lo_q(acc_lo)
  );

  smac_rd #(.LO_W(LO_W), .HI_W(HI_W)) u_rd (
    .clk(clk), .rst(rst), .en(cmd_valid), .op(op),
    .hi(acc_hi), .lo(acc_lo),
    .vld_q(res_valid), .data_q(res_data),
    .z_q(flag_z), .n_q(flag_n), .v_q(flag_v), .c_q(flag_c)
  );
endmodule

// File: rtl/smac_chk.sv
module smac_chk
  import smac_pkg::*;
#(
  parameter int OP_W = 16,
  parameter int LO_W = 32,
  parameter int HI_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic [LO_W-1:0] ld_data,
  input logic [OP_W-1:0] opa,
  input logic [OP_W-1:0] opb,
  input logic            res_valid,
  input logic [LO_W-1:0] res_data,
  input logic            flag_z,
  input logic            flag_n,
  input logic            flag_v,
  input logic            flag_c
);
  logic is_rd, is_rdhi, is_ld, is_clr;

  assign is_rdhi = cmd_valid && (cmd_op == CMD_RDHI);
  assign is_rd   = cmd_valid && (cmd_op == CMD_RDHI || cmd_op == CMD_RDLO);
  assign is_ld   = cmd_valid && (cmd_op == CMD_LDHI || cmd_op == CMD_LDLO);
  assign is_clr  = cmd_valid && (cmd_op == CMD_CLR);

  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> res_valid);

  // R10
  res_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> !res_valid && $stable(res_data));

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rd && $past(is_clr)) |=> (res_data == '0) && flag_z && !flag_n);

  // R3
  hi_sext_chk: assert property (@(posedge clk) disable iff (rst)
    is_rdhi |=> (res_data[LO_W-1:HI_W-1] == '0) || (&res_data[LO_W-1:HI_W-1]));

  // R8
  neg_bit_chk: assert property (@(posedge clk) disable iff (rst)
    is_rdhi |=> flag_n == res_data[LO_W-1]);

  // R5
  ld_flags_chk: assert property (@(posedge clk) disable iff (rst)
    is_ld |=> !flag_v && !flag_c && $stable(flag_z) && $stable(flag_n));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !flag_v && !flag_c);

  // R11
  reset_chk: assert property (@(posedge clk)
    rst |=> !res_valid && (res_data == '0) && !flag_z && !flag_n && !flag_v && !flag_c);
endmodule

bind smac_unit smac_chk #(.OP_W(OP_W), .LO_W(LO_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/tb_smac_unit.sv
module tb_smac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] ld_data = '0;
  logic [15:0] opa = '0, opb = '0;
  logic        res_valid, flag_z, flag_n, flag_v, flag_c;
  logic [31:0] res_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [41:0] m_acc = '0;
  logic [31:0] m_res = '0;
  logic        m_vld = 0, m_z = 0, m_n = 0, m_v = 0, m_c = 0;

  always #4 clk = ~clk;

  smac_unit dut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic signed [31:0] p;
    if (rst) begin
      m_acc = '0; m_res = '0; m_vld = 0;
      m_z = 0; m_n = 0; m_v = 0; m_c = 0;
    end else begin
      m_vld = 0;
      if (cmd_valid) begin
        case (cmd_op)
          3'd1: m_acc = '0;
          3'd2: m_acc[41:32] = ld_data[9:0];
          3'd3: m_acc[31:0] = ld_data;
          3'd4, 3'd5: begin
            m_vld = 1;
            m_res = (cmd_op == 3'd4) ? {{22{m_acc[41]}}, m_acc[41:32]} : m_acc[31:0];
            m_z = (m_acc == 0);
            m_n = m_acc[41];
            m_v = 0; m_c = 0;
          end
          3'd6: begin
            p = $signed(opa) * $signed(opb);
            m_acc = m_acc + {{10{p[31]}}, p};
          end
          default: ;
        endcase
        if (cmd_op == 3'd2 || cmd_op == 3'd3) begin m_v = 0; m_c = 0; end
      end
    end
  end

  // R10: compare against model every cycle
  always @(negedge clk) begin
    if (!done) begin
      check("R10 model", {27'd0, res_valid, res_data, flag_z, flag_n, flag_v, flag_c},
            {27'd0, m_vld, m_res, m_z, m_n, m_v, m_c});
    end
  end

  task automatic issue(bit v, logic [2:0] op, logic [31:0] d = 0,
                       logic [15:0] a = 0, logic [15:0] b = 0);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; ld_data = d; opa = a; opb = b;
  endtask

  // read a part, then compare result and flags {z,n,v,c}
  task automatic rd(bit hi, logic [31:0] exp, logic [3:0] fl, string tag);
    issue(1, hi ? 3'd4 : 3'd5);
    issue(0, 3'd0);
    check({tag, " valid"}, res_valid, 1);
    check({tag, " data"}, res_data, exp);
    check({tag, " flags"}, {flag_z, flag_n, flag_v, flag_c}, fl);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset", {res_valid, res_data, flag_z, flag_n, flag_v, flag_c}, 0);
    rst = 0;

    // R11: reset after non-zero contents
    issue(1, 3'd3, 32'h1234);
    issue(0, 0);
    rst = 1;
    issue(0, 0);
    rst = 0;
    rd(0, 0, 4'b1000, "R11 acc cleared");

    // R1 clear
    issue(1, 3'd3, 32'hDEAD);
    issue(1, 3'd2, 32'h3);
    issue(1, 3'd1);
    rd(0, 0, 4'b1000, "R1 lo");
    rd(1, 0, 4'b1000, "R1 hi");

    // R2 signed products
    issue(1, 3'd1);
    issue(1, 3'd6, 0, 16'd2, 16'd2);
    rd(0, 4, 4'b0000, "R2 2x2 lo");
    rd(1, 0, 4'b0000, "R7 hi zero lo nonzero");
    issue(1, 3'd1);
    issue(1, 3'd6, 0, -16'sd2, 16'd2);
    rd(0, 32'hFFFFFFFC, 4'b0100, "R2 neg lo");
    rd(1, 32'hFFFFFFFF, 4'b0100, "R8 neg hi");
    issue(1, 3'd1);
    issue(1, 3'd6, 0, 16'h8000, 16'h8000);
    rd(0, 32'h40000000, 4'b0000, "R2 min x min");

    // R3 / R4 loads
    issue(1, 3'd1);
    issue(1, 3'd2, 32'hA5A5A5A5);
    rd(1, 32'h000001A5, 4'b0000, "R3 hi load");
    issue(1, 3'd3, 32'hA5A5A5A5);
    rd(0, 32'hA5A5A5A5, 4'b0000, "R4 lo load");
    issue(1, 3'd2, 32'h00000200);
    rd(1, 32'hFFFFFE00, 4'b0100, "R3 hi sign ext");

    // R5 load keeps z/n
    issue(1, 3'd1);
    rd(0, 0, 4'b1000, "R5 prep");
    issue(1, 3'd3, 32'h55);
    issue(0, 0);
    check("R5 flags after load", {flag_z, flag_n, flag_v, flag_c}, 4'b1000);

    // R7 lo zero, hi nonzero
    issue(1, 3'd1);
    issue(1, 3'd2, 32'h1);
    rd(0, 0, 4'b0000, "R7 lo zero hi nonzero");

    // R6 carry chain, R9 no overflow
    issue(1, 3'd1);
    for (int i = 0; i < 8; i++) issue(1, 3'd6, 0, 16'h7FFF, 16'h7FFF);
    rd(0, 32'hFFF80008, 4'b0000, "R6 carry lo");
    rd(1, 32'h1, 4'b0000, "R6 carry hi");
    issue(1, 3'd2, 32'h1FF);
    issue(1, 3'd3, 32'hFFFFFFFF);
    issue(1, 3'd6, 0, 16'd1, 16'd1);
    rd(1, 32'hFFFFFE00, 4'b0100, "R6 wrap to negative");
    rd(0, 0, 4'b0100, "R9 no overflow at wrap");
    issue(1, 3'd2, 32'h3FF);
    issue(1, 3'd3, 32'hFFFFFFFF);
    issue(1, 3'd6, 0, 16'd1, 16'd1);
    rd(1, 0, 4'b1000, "R6 wrap 2^42");

    // R12 ignored commands
    issue(1, 3'd1);
    issue(1, 3'd3, 32'h77);
    issue(0, 3'd1);
    issue(0, 3'd6, 0, 16'h100, 16'h100);
    issue(1, 3'd0, 32'hFFFF, 16'h5, 16'h5);
    issue(1, 3'd7, 32'hFFFF, 16'h5, 16'h5);
    check("R12 no result strobe", res_valid, 0);
    rd(0, 32'h77, 4'b0000, "R12 lo untouched");
    rd(1, 0, 4'b0000, "R12 hi untouched");
    issue(0, 3'd4);
    issue(0, 0);
    check("R12 idle read ignored", res_valid, 0);

    issue(0, 0);
    issue(0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule